// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block follows the low-power state of a double-data-rate SDRAM from the clock-enable pin, the decoded command and an any-bank-open flag from a bank tracker. When clock-enable drops, the block enters a power-down state. The flavour of that power-down depends on whether a row is open. A self-refresh command issued with clock-enable low enters self-refresh instead. Entry into any low-power state, and exit from power-down, are decided on rising clock edges. Exit from self-refresh treats clock-enable as an asynchronous signal and passes it through a two-flop synchroniser.

The block drives two registered enables. One gates the clock input buffer. The other gates every remaining input buffer, which covers command, address, data and mask. Both are on while running. Power-down keeps only the clock buffer. Self-refresh turns both off, leaving only clock-enable alive.

The block also tracks read and write bursts so that clock-enable falling mid-burst is refused and flagged. A separate interval timer raises a refresh-due flag when the average refresh interval has elapsed without an auto-refresh. That interval is 4096 refreshes per 64 ms, which is 3125 cycles at 200 MHz.

Top module: `cke_pwr_ctrl`

## Requirements
- R1: While reset is asserted, and after it, the state is RUN (code 0), both buffer enables are 1, and refresh-due and the error flag are 0.
- R2: In RUN, with no burst in progress and no bank open, clock-enable low at an edge with any command other than self-refresh (code 6) moves the state to precharge power-down (code 1). In that state the clock buffer enable is 1 and the input buffer enable is 0.
- R3: The same entry with the bank-open input high moves the state to active power-down (code 2), with the same enables as R2.
- R4: From either power-down state, clock-enable high at an edge returns the state to RUN after that edge, with both enables 1. While clock-enable stays low, the state is held.
- R5: Command code 6 with clock-enable low and no bank open, in RUN and outside a burst, enters self-refresh (code 3). In self-refresh both enables are 0.
- R6: Command code 6 with clock-enable low while a bank is open is refused. The state goes to active power-down, and the error flag is 1 for the cycle after that edge.
- R7: In self-refresh, if clock-enable is first seen high at edge k, the state is still self-refresh after edges k and k+1 and is RUN after edge k+2.
- R8: A read (code 2) or write (code 3) accepted in RUN with clock-enable high makes the next BURST_LEN/2 edges a burst window (4 with defaults). Clock-enable low at an edge in that window leaves the state in RUN and sets the error flag for the following cycle.
- R9: Refresh-due rises after exactly TREFI counting edges since the last reload, where TREFI = CLK_MHZ*REF_WINDOW_US/REF_ROWS (3125 by default). It then stays high until a reload.
- R10: An auto-refresh command (code 5), accepted in RUN with clock-enable high, reloads the timer. Refresh-due is 0 after that edge.
- R11: Edges at which the state is self-refresh do not advance the timer, so refresh-due cannot change during self-refresh.
- R12: Commands sampled outside RUN, or with clock-enable low, are ignored. An auto-refresh code during power-down does not reload the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock-enable pin level |
| cmd_i | input | 3 | Decoded command: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 auto-refresh, 6 self-refresh, 7 mode set |
| bank_open_i | input | 1 | High while any bank has an open row |
| state_o | output | 2 | 0 RUN, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| clk_buf_en_o | output | 1 | Clock input buffer enable |
| in_buf_en_o | output | 1 | Enable for all other input buffers except clock-enable |
| ref_due_o | output | 1 | Refresh interval has elapsed |
| cke_err_o | output | 1 | Illegal clock-enable drop (mid-burst, or self-refresh with an open bank) |

## Verification
On every cycle the assertions check that the buffer enables agree with the state, and that power-down leads only back to RUN. They also check that a self-refresh exit is backed by clock-enable seen high three edges earlier, that refresh-due stays frozen across self-refresh, that an accepted auto-refresh clears refresh-due, and that precharge power-down is never entered with a bank open. Only the bench scenarios show the exact counts. These are the two-edge synchroniser latency, the length of the burst window and where it ends, the full 3125-cycle interval with and without a self-refresh pause in the middle, and an auto-refresh code being ignored while powered down.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN      = 2'd0,
    PS_PDN_PRE  = 2'd1,
    PS_PDN_ACT  = 2'd2,
    PS_SREF     = 2'd3
  } pwr_state_e;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_AREF = 3'd5,
    CMD_SREF = 3'd6,
    CMD_MRS  = 3'd7
  } sdr_cmd_e;

endpackage

// File: rtl/cke_sync2.sv
// Two-stage resynchroniser for the asynchronous self-refresh exit (R7).
module cke_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst || clr) chain_q <= '0;
    else            chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cke_burst_guard.sv
// Marks the edges that belong to a read or write burst (R8).
module cke_burst_guard #(
  parameter int BURST_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int BEATS = BURST_LEN / 2;
  localparam int BW    = $clog2(BEATS + 1);
  localparam logic [BW-1:0] LOAD = BW'(BEATS);

  logic [BW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                 left_q <= '0;
    else if (start)          left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/cke_ref_timer.sv
// Average refresh interval timer with reload and freeze (R9, R10, R11).
module cke_ref_timer #(
  parameter int CYCLES = 3125
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic hold,
  output logic due
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          due_q;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else if (!hold && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) due_q <= 1'b1;
    end
  end

  assign due = due_q;
endmodule

// File: rtl/cke_pwr_fsm.sv
// Power state sequencing and registered buffer enables (R1-R8).
module cke_pwr_fsm
  import cke_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       bank_open,
  input  logic       burst_busy,
  input  logic       cke_synced,
  output pwr_state_e state,
  output logic       sync_clr,
  output logic       clk_buf_en,
  output logic       in_buf_en,
  output logic       err
);
  pwr_state_e state_q, state_d;
  logic       err_d, clk_en_q, in_en_q, err_q;
  sdr_cmd_e   cmd_e;

  assign cmd_e = sdr_cmd_e'(cmd);

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    unique case (state_q)
      PS_RUN: begin
        if (!cke) begin
          if (burst_busy) begin
            err_d = 1'b1;
          end else if (cmd_e == CMD_SREF && !bank_open) begin
            state_d = PS_SREF;
          end else begin
            state_d = bank_open ? PS_PDN_ACT : PS_PDN_PRE;
            if (cmd_e == CMD_SREF) err_d = 1'b1;
          end
        end
      end
      PS_PDN_PRE, PS_PDN_ACT: begin
        if (cke) state_d = PS_RUN;
      end
      PS_SREF: begin
        if (cke_synced) state_d = PS_RUN;
      end
      default: state_d = PS_RUN;
    endcase
  end

  assign sync_clr = (state_d == PS_SREF) && (state_q != PS_SREF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_RUN;
      clk_en_q <= 1'b1;
      in_en_q  <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      clk_en_q <= (state_d != PS_SREF);
      in_en_q  <= (state_d == PS_RUN);
      err_q    <= err_d;
    end
  end

  assign state      = state_q;
  assign clk_buf_en = clk_en_q;
  assign in_buf_en  = in_en_q;
  assign err        = err_q;
endmodule

// File: rtl/cke_pwr_ctrl.sv
module cke_pwr_ctrl
  import cke_pwr_pkg::*;
#(
  parameter int CLK_MHZ       = 200,
  parameter int REF_WINDOW_US = 64000,
  parameter int REF_ROWS      = 4096,
  parameter int BURST_LEN     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke_i,
  input  logic [2:0] cmd_i,
  input  logic       bank_open_i,
  output logic [1:0] state_o,
  output logic       clk_buf_en_o,
  output logic       in_buf_en_o,
  output logic       ref_due_o,
  output logic       cke_err_o
);
  localparam int TREFI = CLK_MHZ * REF_WINDOW_US / REF_ROWS;

  pwr_state_e state;
  logic       burst_busy, cke_synced, sync_clr;
  logic       accept, rw_start, aref_seen;

  // Commands only count in RUN with clock-enable high (R12).
  assign accept    = (state == PS_RUN) && cke_i;
  assign rw_start  = accept && (cmd_i == CMD_RD || cmd_i == CMD_WR);
  assign aref_seen = accept && (cmd_i == CMD_AREF);

  cke_sync2 #(.STAGES(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .clr (sync_clr),
    .d   (cke_i),
    .q   (cke_synced)
  );

  cke_burst_guard #(.BURST_LEN(BURST_LEN)) i_burst (
    .clk   (clk),
    .rst   (rst),
    .start (rw_start),
    .busy  (burst_busy)
  );

  cke_ref_timer #(.CYCLES(TREFI)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .reload (aref_seen),
    .hold   (state == PS_SREF),
    .due    (ref_due_o)
  );

  cke_pwr_fsm i_fsm (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke_i),
    .cmd        (cmd_i),
    .bank_open  (bank_open_i),
    .burst_busy (burst_busy),
    .cke_synced (cke_synced),
    .state      (state),
    .sync_clr   (sync_clr),
    .clk_buf_en (clk_buf_en_o),
    .in_buf_en  (in_buf_en_o),
    .err        (cke_err_o)
  );

  assign state_o = state;
endmodule

// File: rtl/cke_pwr_ctrl_chk.sv
module cke_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke_i,
  input logic [2:0] cmd_i,
  input logic       bank_open_i,
  input logic [1:0] state_o,
  input logic       clk_buf_en_o,
  input logic       in_buf_en_o,
  input logic       ref_due_o,
  input logic       cke_err_o
);
  assert_run_bufs_R1: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0) |-> (clk_buf_en_o && in_buf_en_o));

  assert_pdn_bufs_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 || state_o == 2'd2) |-> (clk_buf_en_o && !in_buf_en_o));

  assert_pre_pdn_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == 2'd0 && state_o == 2'd1) |-> !$past(bank_open_i));

  assert_pdn_exit_path_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 || state_o == 2'd2) |=> (state_o == $past(state_o) || state_o == 2'd0));

  assert_sref_bufs_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3) |-> (!clk_buf_en_o && !in_buf_en_o));

  assert_sref_exit_cke_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && $past(state_o) == 2'd3) |-> $past(cke_i, 3));

  assert_err_state_R8: assert property (@(posedge clk) disable iff (rst)
    cke_err_o |-> (state_o == 2'd0 || state_o == 2'd2));

  assert_aref_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && cke_i && cmd_i == 3'd5) |=> !ref_due_o);

  assert_ref_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && $past(state_o) == 2'd3) |-> $stable(ref_due_o));
endmodule

bind cke_pwr_ctrl cke_pwr_ctrl_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .cke_i        (cke_i),
  .cmd_i        (cmd_i),
  .bank_open_i  (bank_open_i),
  .state_o      (state_o),
  .clk_buf_en_o (clk_buf_en_o),
  .in_buf_en_o  (in_buf_en_o),
  .ref_due_o    (ref_due_o),
  .cke_err_o    (cke_err_o)
);

// File: tb/test_cke_pwr_ctrl.sv
module test_cke_pwr_ctrl;
  localparam int TREFI = 200 * 64000 / 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke_i = 1'b1;
  logic [2:0] cmd_i = 3'd0;
  logic       bank_open_i = 1'b0;
  logic [1:0] state_o;
  logic       clk_buf_en_o, in_buf_en_o, ref_due_o, cke_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cke_pwr_ctrl i_cke_pwr_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cke_i        (cke_i),
    .cmd_i        (cmd_i),
    .bank_open_i  (bank_open_i),
    .state_o      (state_o),
    .clk_buf_en_o (clk_buf_en_o),
    .in_buf_en_o  (in_buf_en_o),
    .ref_due_o    (ref_due_o),
    .cke_err_o    (cke_err_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    rst = 1'b1; cke_i = 1'b1; cmd_i = 3'd0; bank_open_i = 1'b0;
    step(3);
    check("R1 state in reset", state_o, 0);
    check("R1 clk buf", clk_buf_en_o, 1);
    check("R1 in buf", in_buf_en_o, 1);
    check("R1 ref due", ref_due_o, 0);
    check("R1 err", cke_err_o, 0);
    rst = 1'b0;
    step(1);
    check("R1 state after reset", state_o, 0);
  endtask

  task automatic t_power_down();
    bank_open_i = 1'b0; cke_i = 1'b0; cmd_i = 3'd0;
    step(1);
    check("R2 precharge pdn state", state_o, 1);
    check("R2 clk buf", clk_buf_en_o, 1);
    check("R2 in buf", in_buf_en_o, 0);
    step(3);
    check("R4 held while cke low", state_o, 1);
    cke_i = 1'b1;
    step(1);
    check("R4 exit to run", state_o, 0);
    check("R4 in buf on", in_buf_en_o, 1);
    bank_open_i = 1'b1; cke_i = 1'b0;
    step(1);
    check("R3 active pdn state", state_o, 2);
    check("R3 in buf", in_buf_en_o, 0);
    check("R3 clk buf", clk_buf_en_o, 1);
    cke_i = 1'b1;
    step(1);
    check("R4 exit active pdn", state_o, 0);
  endtask

  task automatic t_sref_refused();
    bank_open_i = 1'b1; cke_i = 1'b0; cmd_i = 3'd6;
    step(1);
    check("R6 refused to active pdn", state_o, 2);
    check("R6 err flagged", cke_err_o, 1);
    cmd_i = 3'd0; cke_i = 1'b1;
    step(1);
    check("R6 back to run", state_o, 0);
    check("R6 err one cycle", cke_err_o, 0);
    bank_open_i = 1'b0;
  endtask

  task automatic t_burst_guard();
    bank_open_i = 1'b0; cke_i = 1'b1; cmd_i = 3'd2;
    step(1);
    cmd_i = 3'd0; cke_i = 1'b0;
    step(1);
    check("R8 drop in burst keeps run", state_o, 0);
    check("R8 drop in burst err", cke_err_o, 1);
    cke_i = 1'b1;
    step(2);
    check("R8 err cleared", cke_err_o, 0);
    cke_i = 1'b0;
    step(1);
    check("R8 last burst edge still guarded", state_o, 0);
    check("R8 last burst edge err", cke_err_o, 1);
    step(1);
    check("R8 after burst enters pdn", state_o, 1);
    check("R8 no err after burst", cke_err_o, 0);
    cke_i = 1'b1;
    step(1);
    cmd_i = 3'd3;
    step(1);
    cmd_i = 3'd0; cke_i = 1'b0;
    step(1);
    check("R8 write burst guarded", cke_err_o, 1);
    cke_i = 1'b1;
    step(4);
  endtask

  task automatic t_refresh_interval();
    cke_i = 1'b1; cmd_i = 3'd5;
    step(1);
    check("R10 reload clears due", ref_due_o, 0);
    cmd_i = 3'd0;
    step(TREFI - 1);
    check("R9 not due one edge early", ref_due_o, 0);
    step(1);
    check("R9 due at interval", ref_due_o, 1);
    step(10);
    check("R9 due held", ref_due_o, 1);
  endtask

  task automatic t_ignored_in_pdn();
    bank_open_i = 1'b0; cke_i = 1'b0; cmd_i = 3'd5;
    step(3);
    check("R12 in pdn", state_o, 1);
    check("R12 aref ignored in pdn", ref_due_o, 1);
    cke_i = 1'b1; cmd_i = 3'd0;
    step(1);
    check("R12 due still set after exit", ref_due_o, 1);
    cmd_i = 3'd5;
    step(1);
    check("R10 aref in run clears due", ref_due_o, 0);
    cmd_i = 3'd0;
  endtask

  task automatic t_self_refresh();
    bank_open_i = 1'b0; cke_i = 1'b1; cmd_i = 3'd5;
    step(1);
    cmd_i = 3'd0;
    step(99);
    cmd_i = 3'd6; cke_i = 1'b0;
    step(1);
    check("R5 sref state", state_o, 3);
    check("R5 clk buf off", clk_buf_en_o, 0);
    check("R5 in buf off", in_buf_en_o, 0);
    cmd_i = 3'd0;
    step(4000);
    check("R11 due frozen in sref", ref_due_o, 0);
    check("R7 stays in sref", state_o, 3);
    cke_i = 1'b1;
    step(1);
    check("R7 edge k still sref", state_o, 3);
    step(1);
    check("R7 edge k+1 still sref", state_o, 3);
    step(1);
    check("R7 edge k+2 run", state_o, 0);
    check("R7 bufs on", in_buf_en_o, 1);
    step(TREFI - 101);
    check("R11 count resumed not yet due", ref_due_o, 0);
    step(1);
    check("R11 due after resumed count", ref_due_o, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_power_down();
    t_sref_refused();
    t_burst_guard();
    t_refresh_interval();
    t_ignored_in_pdn();
    t_self_refresh();
    done = 1'b1;
    finish_run();
  end
endmodule